// File: doc/BRIEF.md
# Fan Cooling Demand to RPM Mapper

This block turns a set of temperature readings into a target fan speed. Every sensor has two programmable fan levels: a temperature where no cooling is needed and one where full cooling is needed. Between those two levels the sensor's demand rises linearly from 0 % to 100 %. The block takes the largest demand over all sensors and maps it onto a speed range between a programmable minimum and maximum RPM. A demand of 0 % switches the fan off. Any non-zero demand gives at least the minimum RPM.

A computation starts with a one-cycle `go` pulse while the block is idle. At that edge the block captures every input. A single shared restoring divider then works through the sensors one after another and finishes with the RPM scaling. A one-cycle `done` pulse marks the moment `demand_pct` and `target_rpm` take their new values. A mode input can replace the automatic result with a fixed percentage or a fixed RPM. Selecting automatic mode again on the next computation returns control to the temperatures.

Top module: `fan_demand_mapper`

## Requirements
- R1: After reset, `target_rpm` is 0, `demand_pct` is 0 and `done` is low.
- R2: Per-sensor demand is defined as follows:
  - 0 when the reading is at or below the sensor's fan-off level.
  - 100 when the reading is at or above its fan-max level.
  - Otherwise floor((T − off) × 100 / (max − off)).
  - Sensor i occupies bits [i×TW +: TW] of `temps`, `off_lvl` and `max_lvl`.
- R3: `demand_pct` is the largest per-sensor demand. A sensor whose fan-max level is not above its fan-off level contributes nothing; if no sensor contributes, the demand is 0.
- R4: A percentage p maps to RPM as follows:
  - p = 0 gives 0.
  - p from 1 to 100 gives `rpm_lo` + floor((p − 1) × (`rpm_hi` − `rpm_lo`) / 99), so 1 % gives `rpm_lo`.
  - When `rpm_hi` ≤ `rpm_lo`, any non-zero p gives `rpm_lo`.
- R5: `mode` encodings:
  - 2'b00 and 2'b11 use the automatic demand.
  - 2'b01 uses `man_pct`, with values above 100 clamped to 100.
  - `demand_pct` always reports the automatic demand.
- R6: With `mode` = 2'b10, `target_rpm` equals `man_rpm` unchanged.
- R7: A `go` pulse while idle captures all inputs. `done` is high for exactly one cycle, in the cycle where the new outputs first appear. The outputs hold their values between updates.
- R8: A `go` pulse while a computation is running is ignored. Input changes after the capture do not affect the running result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse, taken only while idle |
| temps | input | NS*TW | Packed sensor readings |
| off_lvl | input | NS*TW | Packed per-sensor fan-off levels |
| max_lvl | input | NS*TW | Packed per-sensor fan-max levels |
| mode | input | 2 | 00/11 automatic, 01 fixed percent, 10 fixed RPM |
| man_pct | input | 8 | Fixed percentage for mode 01 |
| man_rpm | input | RW | Fixed RPM for mode 10 |
| rpm_lo | input | RW | Minimum running RPM |
| rpm_hi | input | RW | Maximum RPM |
| demand_pct | output | 7 | Automatic overall demand of the last computation |
| target_rpm | output | RW | Target fan speed |
| done | output | 1 | One-cycle pulse when outputs update |

## Verification
A wrong sensor index or a wrong running maximum shows up as a `demand_pct` that differs from the largest clamped ramp value. A fault in the divider's remainder or quotient shifts the result by one or more percent or RPM. Such errors appear at the `done` pulse of the same computation, a little over a hundred cycles after `go` with default parameters. Faults in capturing the inputs or in the busy guard show up when `go` is pulsed again mid-run or when inputs change mid-run: the next `done` then carries values taken from the wrong inputs.

// File: rtl/fan_demand_mapper.sv
module fan_demand_mapper #(
  parameter int NS = 4,
  parameter int TW = 10,
  parameter int RW = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NS*TW-1:0] temps,
  input  logic [NS*TW-1:0] off_lvl,
  input  logic [NS*TW-1:0] max_lvl,
  input  logic [1:0]       mode,
  input  logic [7:0]       man_pct,
  input  logic [RW-1:0]    man_rpm,
  input  logic [RW-1:0]    rpm_lo,
  input  logic [RW-1:0]    rpm_hi,
  output logic [6:0]       demand_pct,
  output logic [RW-1:0]    target_rpm,
  output logic             done
);
  localparam int DW  = (TW > RW) ? TW + 7 : RW + 7;
  localparam int DVW = (TW > 7) ? TW : 7;
  localparam int CW  = $clog2(DW + 1);
  localparam int KW  = (NS > 1) ? $clog2(NS) : 1;

  typedef enum logic [2:0] {ST_IDLE, ST_SENS, ST_DIVS, ST_MAP, ST_DIVR} st_t;

  st_t              st;
  logic [KW-1:0]    k;
  logic [NS*TW-1:0] t_q, lo_q, hi_q;
  logic [1:0]       mode_q;
  logic [7:0]       mpct_q;
  logic [RW-1:0]    mrpm_q, rmin_q, rmax_q;
  logic [6:0]       best;
  logic [DVW-1:0]   rem, dvs;
  logic [DW-1:0]    quo;
  logic [CW-1:0]    cnt;

  logic [TW-1:0] cur_t, cur_lo, cur_hi, dt, dl;
  assign cur_t  = t_q[k*TW +: TW];
  assign cur_lo = lo_q[k*TW +: TW];
  assign cur_hi = hi_q[k*TW +: TW];
  assign dt     = cur_t - cur_lo;
  assign dl     = cur_hi - cur_lo;

  logic excl, below, above, skip;
  assign excl  = cur_hi <= cur_lo;
  assign below = cur_t <= cur_lo;
  assign above = cur_t >= cur_hi;
  assign skip  = excl | below | above;

  logic [DW-1:0] num_s;
  assign num_s = DW'(dt) * DW'(100);

  logic [RW-1:0] span_r;
  assign span_r = (rmax_q > rmin_q) ? rmax_q - rmin_q : '0;

  logic [6:0] pct_sel, pm1;
  assign pct_sel = (mode_q == 2'b01) ? ((mpct_q > 8'd100) ? 7'd100 : mpct_q[6:0]) : best;
  assign pm1     = pct_sel - 7'd1;

  logic [DW-1:0] num_r;
  assign num_r = DW'(pm1) * DW'(span_r);

  logic [DVW:0]   r2, rdiff;
  logic           ge;
  logic [DVW-1:0] rem_n;
  logic [DW-1:0]  quo_n;
  assign r2    = {rem, quo[DW-1]};
  assign rdiff = r2 - {1'b0, dvs};
  assign ge    = r2 >= {1'b0, dvs};
  assign rem_n = ge ? rdiff[DVW-1:0] : r2[DVW-1:0];
  assign quo_n = {quo[DW-2:0], ge};

  logic last_k;
  assign last_k = (k == KW'(NS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      k <= '0;
      t_q <= '0;
      lo_q <= '0;
      hi_q <= '0;
      mode_q <= '0;
      mpct_q <= '0;
      mrpm_q <= '0;
      rmin_q <= '0;
      rmax_q <= '0;
      best <= '0;
      rem <= '0;
      dvs <= '0;
      quo <= '0;
      cnt <= '0;
      demand_pct <= '0;
      target_rpm <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (go) begin
          t_q <= temps;
          lo_q <= off_lvl;
          hi_q <= max_lvl;
          mode_q <= mode;
          mpct_q <= man_pct;
          mrpm_q <= man_rpm;
          rmin_q <= rpm_lo;
          rmax_q <= rpm_hi;
          k <= '0;
          best <= '0;
          st <= ST_SENS;
        end
        ST_SENS: begin
          if (skip) begin
            if (!excl && !below && above) best <= 7'd100;
            if (last_k) st <= ST_MAP;
            else k <= k + 1'b1;
          end else begin
            rem <= '0;
            quo <= num_s;
            dvs <= DVW'(dl);
            cnt <= CW'(DW);
            st <= ST_DIVS;
          end
        end
        ST_DIVS: begin
          rem <= rem_n;
          quo <= quo_n;
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) begin
            if (quo_n[6:0] > best) best <= quo_n[6:0];
            if (last_k) st <= ST_MAP;
            else begin
              k <= k + 1'b1;
              st <= ST_SENS;
            end
          end
        end
        ST_MAP: begin
          if (mode_q == 2'b10 || pct_sel == 7'd0 || pct_sel == 7'd1 || span_r == '0) begin
            if (mode_q == 2'b10) target_rpm <= mrpm_q;
            else if (pct_sel == 7'd0) target_rpm <= '0;
            else target_rpm <= rmin_q;
            demand_pct <= best;
            done <= 1'b1;
            st <= ST_IDLE;
          end else begin
            rem <= '0;
            quo <= num_r;
            dvs <= DVW'(99);
            cnt <= CW'(DW);
            st <= ST_DIVR;
          end
        end
        ST_DIVR: begin
          rem <= rem_n;
          quo <= quo_n;
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) begin
            target_rpm <= rmin_q + quo_n[RW-1:0];
            demand_pct <= best;
            done <= 1'b1;
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2
  demand_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> demand_pct <= 7'd100);

  // R4
  zero_pct_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q != 2'b10 && pct_sel == 7'd0) |-> target_rpm == '0);

  // R4
  rpm_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q != 2'b10 && pct_sel != 7'd0) |->
      (target_rpm >= rmin_q && (rmax_q < rmin_q || target_rpm <= rmax_q)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |=> ($stable(target_rpm) && $stable(demand_pct)));

  // R8
  busy_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |=> ($stable(mode_q) && $stable(t_q) && $stable(rmin_q)));
endmodule

// File: tb/fan_demand_mapper_bench.sv
module fan_demand_mapper_bench;
  localparam int NS = 4;
  localparam int TW = 10;
  localparam int RW = 14;
  localparam logic [39:0] LO = {4{10'd330}};
  localparam logic [39:0] HI = {4{10'd360}};
  localparam logic [39:0] COLD = {4{10'd300}};

  typedef struct packed {
    logic [39:0] t;
    logic [39:0] lo;
    logic [39:0] hi;
    logic [1:0]  md;
    logic [7:0]  mp;
    logic [13:0] mr;
    logic [13:0] rmin;
    logic [13:0] rmax;
    logic [6:0]  edem;
    logic [13:0] erpm;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{COLD, LO, HI, 2'd0, 8'd0, 14'd0, 14'd1000, 14'd5950, 7'd0, 14'd0, 4'd4},      // R4 zero -> off
    '{{10'd300,10'd300,10'd300,10'd345}, LO, HI, 2'd0, 8'd0, 14'd0, 14'd1000, 14'd5950, 7'd50, 14'd3450, 4'd2}, // R2
    '{{10'd300,10'd331,10'd340,10'd300}, LO, HI, 2'd0, 8'd0, 14'd0, 14'd1000, 14'd5950, 7'd33, 14'd2600, 4'd3}, // R3
    '{{10'd360,10'd300,10'd300,10'd330}, LO, HI, 2'd0, 8'd0, 14'd0, 14'd1000, 14'd5950, 7'd100, 14'd5950, 4'd2}, // R2 edges
    '{{10'd300,10'd300,10'd400,10'd300}, {10'd330,10'd330,10'd350,10'd330}, {10'd360,10'd360,10'd350,10'd360},
      2'd0, 8'd0, 14'd0, 14'd1000, 14'd5950, 7'd0, 14'd0, 4'd3},                      // R3 excluded
    '{{10'd332,10'd300,10'd300,10'd300}, LO, {10'd333,10'd360,10'd360,10'd360},
      2'd0, 8'd0, 14'd0, 14'd1000, 14'd5950, 7'd66, 14'd4250, 4'd2},                  // R2 floor
    '{COLD, LO, HI, 2'd1, 8'd1, 14'd0, 14'd1000, 14'd5950, 7'd0, 14'd1000, 4'd4},   // R4 1% -> min
    '{{10'd300,10'd300,10'd300,10'd345}, LO, HI, 2'd1, 8'd150, 14'd0, 14'd1000, 14'd5950, 7'd50, 14'd5950, 4'd5}, // R5 clamp
    '{{10'd300,10'd300,10'd300,10'd345}, LO, HI, 2'd1, 8'd0, 14'd0, 14'd1000, 14'd5950, 7'd50, 14'd0, 4'd5},     // R5
    '{{10'd300,10'd300,10'd300,10'd345}, LO, HI, 2'd2, 8'd0, 14'd1234, 14'd1000, 14'd5950, 7'd50, 14'd1234, 4'd6}, // R6
    '{{10'd300,10'd300,10'd300,10'd345}, LO, HI, 2'd3, 8'd0, 14'd0, 14'd1000, 14'd5950, 7'd50, 14'd3450, 4'd5},  // R5 mode 11
    '{{10'd300,10'd300,10'd300,10'd345}, LO, HI, 2'd0, 8'd0, 14'd0, 14'd800, 14'd3000, 7'd50, 14'd1888, 4'd4},   // R4 rounding
    '{{10'd300,10'd300,10'd300,10'd345}, LO, HI, 2'd0, 8'd0, 14'd0, 14'd2000, 14'd1500, 7'd50, 14'd2000, 4'd4},  // R4 inverted
    '{{10'd300,10'd300,10'd300,10'd301}, {10'd330,10'd330,10'd330,10'd300}, {10'd360,10'd360,10'd360,10'd400},
      2'd0, 8'd0, 14'd0, 14'd1000, 14'd5950, 7'd1, 14'd1000, 4'd4},                   // R4 auto 1%
    '{COLD, LO, HI, 2'd1, 8'd2, 14'd0, 14'd1000, 14'd5950, 7'd0, 14'd1050, 4'd4},   // R4
    '{{10'd300,10'd300,10'd300,10'd359}, LO, HI, 2'd0, 8'd0, 14'd0, 14'd1000, 14'd5950, 7'd96, 14'd5750, 4'd2}  // R2
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic [NS*TW-1:0] temps = '0, off_lvl = '0, max_lvl = '0;
  logic [1:0] mode = '0;
  logic [7:0] man_pct = '0;
  logic [RW-1:0] man_rpm = '0, rpm_lo = '0, rpm_hi = '0;
  logic [6:0] demand_pct;
  logic [RW-1:0] target_rpm;
  logic done;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fan_demand_mapper #(.NS(NS), .TW(TW), .RW(RW)) u_fan_demand_mapper (
    .clk(clk), .rst_n(rst_n), .go(go), .temps(temps), .off_lvl(off_lvl),
    .max_lvl(max_lvl), .mode(mode), .man_pct(man_pct), .man_rpm(man_rpm),
    .rpm_lo(rpm_lo), .rpm_hi(rpm_hi), .demand_pct(demand_pct),
    .target_rpm(target_rpm), .done(done));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    temps = v.t; off_lvl = v.lo; max_lvl = v.hi; mode = v.md;
    man_pct = v.mp; man_rpm = v.mr; rpm_lo = v.rmin; rpm_hi = v.rmax;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (done) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rpm", int'(target_rpm), 0);
    check("R1 demand", int'(demand_pct), 0);
    check("R1 done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int n = 0; n < NV; n++) begin
      apply(VECS[n]);
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      wait_done(ok);
      check($sformatf("R7 done row %0d", n), int'(ok), 1);
      check($sformatf("R%0d demand row %0d", VECS[n].req, n), int'(demand_pct), int'(VECS[n].edem));
      check($sformatf("R%0d rpm row %0d", VECS[n].req, n), int'(target_rpm), int'(VECS[n].erpm));
    end

    // R7 one-cycle done and held outputs
    @(negedge clk);
    check("R7 done width", int'(done), 0);
    apply(VECS[3]);
    repeat (5) @(negedge clk);
    check("R7 hold rpm", int'(target_rpm), 5750);

    // R8 go during busy ignored, inputs changed after capture
    apply(VECS[1]);
    go = 1'b1;
    @(negedge clk);
    apply(VECS[3]);
    @(negedge clk);
    go = 1'b0;
    wait_done(ok);
    check("R8 done", int'(ok), 1);
    check("R8 demand", int'(demand_pct), 50);
    check("R8 rpm", int'(target_rpm), 3450);
    repeat (4) @(negedge clk);
    check("R8 no second done", int'(done), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule